// File: doc/BRIEF.md
# Serial-Loaded DAC Register Interface

This block is the digital front end of a current-output converter. A host writes it over a three-wire link: an active-low frame select, a serial clock and a data line. While the frame select is low, the block assembles a 16-bit word, most significant bit first. The top two bits form a command, and the next bits form the converter code. When the frame select returns high, the word moves through an input latch and is decoded. A load command updates the parallel DAC code. Another command moves data capture from the falling to the rising serial-clock edge and stops the converter core until a later load.

All three serial pins are sampled by the system clock through a synchronizer, so the serial clock must run several times slower than the system clock. The block does not clear its shift register between frames. A frame with too few edges latches whatever word the register then holds, stale bits included. A frame with too many edges keeps only the last 16 bits. A readback line returns the previous register contents during each frame.

Top module: `dac_serial_if`

## Requirements
- R1: After a synchronous reset, dac_code is 0, core_active is 1, sdo is 0 and data capture is on the falling serial-clock edge.
- R2: A frame whose word has bits [15:14] = 00 loads bits [13:14-RES] into dac_code once sync_n rises. The remaining low bits of the 14-bit data field have no effect on dac_code.
- R3: In falling-edge mode, sdin is captured only on falling edges of sclk; a level present only around rising edges is never taken.
- R4: A word with bits [15:14] = 11 switches capture to rising sclk edges, drives core_active to 0 and leaves dac_code unchanged. Rising-edge capture persists across later frames until reset.
- R5: A word with bits [15:14] = 01 or 10 leaves dac_code, core_active and the capture edge unchanged.
- R6: sclk edges while sync_n is high shift nothing into the register.
- R7: A frame with fewer than 16 edges still latches and decodes at the rise of sync_n. The register is not cleared, so bits from the earlier word fill the upper positions.
- R8: A frame with more than 16 edges decodes only the last 16 bits received.
- R9: While sync_n is low, sdo presents the shift-register contents from the start of the frame, MSB first, advancing on each rising sclk edge and giving 0 after 16 bits. While sync_n is high, sdo is 0.
- R10: Every load command, including one received in rising-edge mode, sets core_active to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low frame select and chip enable |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | RES | Parallel code held in the DAC register |
| core_active | output | 1 | High while the converter core is operative |
| sdo | output | 1 | Serial readback of the previous register contents |

## Verification
The bench sweeps every 8-bit code through load frames whose ignored low bits carry noise. In each frame it inverts sdin between the capture edge and the opposite edge, so a design that samples on the wrong edge loads garbage. A 12-edge frame after a full word checks that stale bits are kept and that the word they form is decoded. That word is a rising-edge command here, so a design that clears the register or drops short frames would keep the core active. A 20-edge frame whose first four bits would form a command checks that only the last 16 bits count. Reserved commands, edges outside a frame and a reset taken in rising-edge mode check that the capture edge is neither lost early nor kept after reset. Readback is compared bit by bit on every frame.

// File: rtl/dac_sif_pkg.sv
package dac_sif_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 14;
  typedef enum logic [1:0] {
    CMD_LOAD = 2'b00,
    CMD_RSV1 = 2'b01,
    CMD_RSV2 = 2'b10,
    CMD_RISE = 2'b11
  } cmd_e;
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RST_VAL;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sif_edge.sv
module sif_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sync_s,
  input  logic rise_mode,
  output logic cap_stb,
  output logic rb_stb,
  output logic open_stb,
  output logic close_stb
);
  logic sclk_d, sync_d, in_frame, sclk_rise, sclk_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      sync_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      sync_d <= sync_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  // frame body: select low now and on the previous sample
  assign in_frame  = ~sync_s & ~sync_d;
  assign open_stb  = ~sync_s & sync_d;
  assign close_stb = sync_s & ~sync_d;
  assign cap_stb   = in_frame & (rise_mode ? sclk_rise : sclk_fall);
  assign rb_stb    = in_frame & sclk_rise;
endmodule

// File: rtl/sif_shift.sv
module sif_shift
  import dac_sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_s,
  input  logic              sdin_s,
  input  logic              cap_stb,
  input  logic              rb_stb,
  input  logic              open_stb,
  input  logic              close_stb,
  output logic [WORD_W-1:0] sreg,
  output logic              sdo
);
  logic [WORD_W-1:0] rb_q;

  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else if (cap_stb) sreg <= {sreg[WORD_W-2:0], sdin_s};
  end

  always_ff @(posedge clk) begin
    if (rst) rb_q <= '0;
    else if (open_stb) rb_q <= sreg;
    else if (close_stb) rb_q <= '0;
    else if (rb_stb) rb_q <= {rb_q[WORD_W-2:0], 1'b0};
  end

  assign sdo = rb_q[WORD_W-1];

  // R6: register holds while the frame select stays high
  a_r6_hold_outside_frame: assert property (@(posedge clk) disable iff (rst)
    (sync_s && $past(sync_s)) |-> $stable(sreg));
  // R9: readback idles low between frames
  a_r9_sdo_idle: assert property (@(posedge clk) disable iff (rst)
    (sync_s && $past(sync_s)) |-> !sdo);
endmodule

// File: rtl/sif_decode.sv
module sif_decode
  import dac_sif_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              close_stb,
  input  logic [WORD_W-1:0] word_in,
  output logic [RES-1:0]    dac_code,
  output logic              core_active,
  output logic              rise_mode
);
  logic [WORD_W-1:0] latch_q;
  logic              latch_vld;
  cmd_e              cmd;
  logic [RES-1:0]    code_field;

  if (!(RES == 8 || RES == 10 || RES == 12 || RES == 14)) begin : g_bad_res
    $error("RES must be 8, 10, 12 or 14");
  end

  assign cmd        = cmd_e'(latch_q[WORD_W-1 -: 2]);
  assign code_field = latch_q[DATA_W-1 -: RES];

  // input latch: the whole word as it stood at frame close
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      latch_vld <= 1'b0;
    end else begin
      latch_vld <= close_stb;
      if (close_stb) latch_q <= word_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code    <= '0;
      core_active <= 1'b1;
      rise_mode   <= 1'b0;
    end else if (latch_vld) begin
      case (cmd)
        CMD_LOAD: begin
          dac_code    <= code_field;
          core_active <= 1'b1;
        end
        CMD_RISE: begin
          rise_mode   <= 1'b1;
          core_active <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R2: the DAC register moves only after a latched load command
  a_r2_code_only_on_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> $past(latch_vld && latch_q[WORD_W-1 -: 2] == 2'b00));
  // R4: rising-edge capture is never dropped without reset
  a_r4_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    !$fell(rise_mode));
  // R4: the core stops only after a rising-edge command
  a_r4_inactive_after_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(core_active) |-> $past(latch_vld && latch_q[WORD_W-1 -: 2] == 2'b11));
  // R10: a load command always reactivates the core
  a_r10_active_after_load: assert property (@(posedge clk) disable iff (rst)
    (latch_vld && latch_q[WORD_W-1 -: 2] == 2'b00) |=> core_active);
endmodule

// File: rtl/dac_serial_if.sv
module dac_serial_if
  import dac_sif_pkg::*;
#(
  parameter int RES = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sync_n,
  input  logic           sclk,
  input  logic           sdin,
  output logic [RES-1:0] dac_code,
  output logic           core_active,
  output logic           sdo
);
  logic [2:0]        pins_s;
  logic              sync_s, sclk_s, sdin_s;
  logic              rise_mode, cap_stb, rb_stb, open_stb, close_stb;
  logic [WORD_W-1:0] sreg;

  sif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d({sync_n, sclk, sdin}), .q(pins_s)
  );
  assign {sync_s, sclk_s, sdin_s} = pins_s;

  sif_edge u_edge (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sync_s(sync_s),
    .rise_mode(rise_mode), .cap_stb(cap_stb), .rb_stb(rb_stb),
    .open_stb(open_stb), .close_stb(close_stb)
  );

  sif_shift u_shift (
    .clk(clk), .rst(rst), .sync_s(sync_s), .sdin_s(sdin_s),
    .cap_stb(cap_stb), .rb_stb(rb_stb), .open_stb(open_stb),
    .close_stb(close_stb), .sreg(sreg), .sdo(sdo)
  );

  sif_decode #(.RES(RES)) u_decode (
    .clk(clk), .rst(rst), .close_stb(close_stb), .word_in(sreg),
    .dac_code(dac_code), .core_active(core_active), .rise_mode(rise_mode)
  );
endmodule

// File: tb/dac_serial_if_tb.sv
module dac_serial_if_tb;
  localparam int RES  = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic [RES-1:0] dac_code;
  logic core_active, sdo;

  int nvec = 0, nerr = 0;
  logic [15:0]    m_sreg = '0;
  logic [RES-1:0] m_dac = '0;
  logic           m_act = 1'b1, m_rise = 1'b0;

  always #10 clk = ~clk;

  dac_serial_if #(.RES(RES)) u_dut (
    .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .core_active(core_active), .sdo(sdo)
  );

  task automatic wclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sync_n = 1'b1; sclk = 1'b1; sdin = 1'b0;
    wclk(5);
    rst = 1'b0;
    m_sreg = '0; m_dac = '0; m_act = 1'b1; m_rise = 1'b0;
    wclk(5);
  endtask

  // send the low n bits of stream, MSB first; model and check afterwards
  task automatic frame(input logic [31:0] stream, input int n, input string req);
    logic [15:0] prev;
    int rb_bad;
    logic b;
    prev = m_sreg;
    rb_bad = 0;
    sclk = m_rise ? 1'b0 : 1'b1;
    wclk(HALF);
    sync_n = 1'b0;
    wclk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      b = stream[i];
      sdin = b;
      if (!m_rise) begin
        wclk(HALF); sclk = 1'b0;
        wclk(HALF); sdin = ~b;
        if (sdo !== ((n - 1 - i) < 16 ? prev[15 - (n - 1 - i)] : 1'b0)) rb_bad++;
        sclk = 1'b1;
      end else begin
        wclk(HALF);
        if (sdo !== ((n - 1 - i) < 16 ? prev[15 - (n - 1 - i)] : 1'b0)) rb_bad++;
        sclk = 1'b1;
        wclk(HALF); sdin = ~b; sclk = 1'b0;
      end
      m_sreg = {m_sreg[14:0], b};
    end
    wclk(HALF);
    sync_n = 1'b1;
    wclk(20);
    case (m_sreg[15:14])
      2'b00: begin m_dac = m_sreg[13 -: RES]; m_act = 1'b1; end
      2'b11: begin m_rise = 1'b1; m_act = 1'b0; end
      default: ;
    endcase
    check({req, " dac_code"}, 32'(dac_code), 32'(m_dac));
    check({req, " core_active"}, 32'(core_active), 32'(m_act));
    check("R9 readback bits", 32'(rb_bad), 32'd0);
    check("R9 sdo idle", 32'(sdo), 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1 reset state
    check("R1 dac_code", 32'(dac_code), 0);
    check("R1 core_active", 32'(core_active), 1);
    check("R1 sdo", 32'(sdo), 0);

    // R2/R3/R10 sweep of every code with noise in ignored low bits
    for (int c = 0; c < 256; c++) begin
      logic [15:0] w;
      w = {2'b00, 8'(c), 6'(c ^ 'h2A)};
      frame({16'h0, w}, 16, "R2 R3 R10 sweep");
    end

    // R6 edges with select high are ignored; empty frame relatches
    sdin = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b0; wclk(HALF); sclk = 1'b1; wclk(HALF);
    end
    frame(32'h0, 0, "R6 no shift outside frame");

    // R5 reserved commands
    frame({16'h0, 16'h4F00}, 16, "R5 cmd 01");
    frame({16'h0, 16'h8C40}, 16, "R5 cmd 10");
    frame({16'h0, 16'h1640}, 16, "R5 mode kept");

    // R8 overlong frame: leading nibble would be a rise command
    frame({12'h0, 4'hC, 16'h1A5C}, 20, "R8 overlong");

    // R7 short frame leaves stale upper bits; result is a rise command (R4)
    frame({16'h0, 16'h3FFF}, 16, "R7 full word");
    frame({20'h0, 12'h320}, 12, "R7 R4 short frame");

    // R4 rising-edge mode: load still works and reactivates (R10)
    frame({16'h0, 16'h2B80}, 16, "R4 R10 rising load");
    frame({16'h0, 16'hC000}, 16, "R4 rise again");
    frame({16'h0, 16'h0D00}, 16, "R4 R10 rising reload");

    // R1 reset restores falling capture
    do_reset();
    check("R1 dac_code after reset", 32'(dac_code), 0);
    check("R1 core_active after reset", 32'(core_active), 1);
    frame({16'h0, 16'h3540}, 16, "R1 R3 falling after reset");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule